// File: doc/BRIEF.md
# Clock Generator Reprogramming Sequencer

This block is a small register-bus master. It moves a clock generator to a new pre-divider, multiplier and post-divider setting without glitching the clock it drives. A single start strobe latches the three values. The sequencer then runs a fixed, gated series of bus writes. It pauses for a settling interval, and it polls the generator's busy flag before each of the two phases that depend on the generator being ready.

The output is switched off first. The dividers and multiplier are then loaded, with a divisor-enable flag set on both divider words, and the new setting is committed by an arm-then-fire command pair. The output is switched back on only after the generator reports idle a second time. Every access is held until the bus acknowledges it. A poll that stays busy for too long abandons the sequence and reports an error together with completion.

Top module: `pllseq_top`

## Requirements
- R1: While reset is held and after it is released, no bus request is made, and `done` and `err` are low.
- R2: A one-cycle `start` in idle latches `pre_in`, `mul_in` and `post_in`. The first access is then a write of 0 to word offset 0, the output-control register.
- R3: The next writes are, in order: offset 5 with data `pre_in` ORed with bit 15 (divisor enable), then offset 4 with data `mul_in` zero-extended.
- R4: After the multiplier write is acknowledged, the bus stays idle for exactly `SETTLE_CYC` cycles. The first status read follows.
- R5: A poll phase reads offset 15 repeatedly. It ends with the first acknowledged read whose bit 0 (busy) is 0. Reads go to no other offset.
- R6: After the first poll, the writes are, in order: offset 6 with `post_in` ORed with bit 15, then 1 to offset 16 (command enable), then 1 to offset 14 (command fire).
- R7: A second poll follows, then a write of 1 to offset 0. After that, `done` pulses for one cycle with `err` low and no request active.
- R8: Each access keeps `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` stable until `bus_ack`. The next access may begin on the following cycle.
- R9: A poll phase can time out. If an acknowledged status read still shows busy once the phase has run `POLL_LIMIT` or more cycles, the sequence stops with no further writes, and `done` pulses with `err` high.
- R10: While a sequence runs, `start` and changes on the three value inputs have no effect on the writes, and no second sequence follows.
- R11: `err` stays high after an aborted sequence until the next `start`. That start clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a reprogramming sequence (sampled in idle only) |
| pre_in | input | PRE_W | New pre-divider value |
| mul_in | input | MUL_W | New multiplier value |
| post_in | input | POST_W | New post-divider value |
| bus_req | output | 1 | Access request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Register word offset |
| bus_wdata | output | DATA_W | Write data |
| bus_ack | input | 1 | Access acknowledge |
| bus_rdata | input | DATA_W | Read data, valid with `bus_ack` |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Poll timeout flag, valid with `done`, held until next start |

## Verification
The assertions take for granted that the bus raises `bus_ack` only while a request is pending and for one cycle per access. They also assume `bus_rdata` is meaningful only in that cycle. The bench's slave model respects both: it acknowledges after a configurable number of wait cycles, drops the acknowledge on the next cycle, and returns the busy bit only on an acknowledged read of offset 15. The sweep covers combinations of values, busy-read counts and ack latency. Separate runs hold busy past the poll limit in each of the two poll phases.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OUT_OFF,
        ST_LOAD_PRE,
        ST_LOAD_MUL,
        ST_SETTLE,
        ST_POLL_LOCK,
        ST_LOAD_POST,
        ST_ARM,
        ST_FIRE,
        ST_POLL_CMD,
        ST_OUT_ON,
        ST_FINISH
    } step_e;

    // word offsets inside one clock domain's register window
    localparam int OFS_CTRL   = 0;
    localparam int OFS_MUL    = 4;
    localparam int OFS_PRE    = 5;
    localparam int OFS_POST   = 6;
    localparam int OFS_CMD    = 14;
    localparam int OFS_STATUS = 15;
    localparam int OFS_CMDEN  = 16;

    localparam int DIV_EN_BIT = 15;
    localparam int BUSY_BIT   = 0;

endpackage

// File: rtl/pllseq_interval.sv
// Saturating cycle counter: restarts from zero whenever run is low,
// flags expiry once run has been high for LIMIT cycles.
module pllseq_interval #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q != LAST) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/pllseq_access_map.sv
// Decodes the current step into the bus access it must issue.
module pllseq_access_map
    import pllseq_pkg::*;
#(
    parameter int PRE_W  = 5,
    parameter int MUL_W  = 4,
    parameter int POST_W = 5,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  step_e             step,
    input  logic [PRE_W-1:0]  pre,
    input  logic [MUL_W-1:0]  mul,
    input  logic [POST_W-1:0] post,
    output logic              req,
    output logic              we,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata
);
    localparam logic [DATA_W-1:0] DIV_EN = DATA_W'(1) << DIV_EN_BIT;
    localparam logic [DATA_W-1:0] ONE    = DATA_W'(1);

    always_comb begin
        req   = 1'b1;
        we    = 1'b1;
        addr  = '0;
        wdata = '0;
        case (step)
            ST_OUT_OFF:   begin addr = ADDR_W'(OFS_CTRL);  wdata = '0; end
            ST_LOAD_PRE:  begin addr = ADDR_W'(OFS_PRE);   wdata = DIV_EN | DATA_W'(pre); end
            ST_LOAD_MUL:  begin addr = ADDR_W'(OFS_MUL);   wdata = DATA_W'(mul); end
            ST_LOAD_POST: begin addr = ADDR_W'(OFS_POST);  wdata = DIV_EN | DATA_W'(post); end
            ST_ARM:       begin addr = ADDR_W'(OFS_CMDEN); wdata = ONE; end
            ST_FIRE:      begin addr = ADDR_W'(OFS_CMD);   wdata = ONE; end
            ST_OUT_ON:    begin addr = ADDR_W'(OFS_CTRL);  wdata = ONE; end
            ST_POLL_LOCK,
            ST_POLL_CMD:  begin we = 1'b0; addr = ADDR_W'(OFS_STATUS); end
            default:      begin req = 1'b0; we = 1'b0; end
        endcase
    end
endmodule

// File: rtl/pllseq_top.sv
module pllseq_top
    import pllseq_pkg::*;
#(
    parameter int PRE_W      = 5,
    parameter int MUL_W      = 4,
    parameter int POST_W     = 5,
    parameter int ADDR_W     = 5,
    parameter int DATA_W     = 32,
    parameter int SETTLE_CYC = 100000,
    parameter int POLL_LIMIT = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PRE_W-1:0]  pre_in,
    input  logic [MUL_W-1:0]  mul_in,
    input  logic [POST_W-1:0] post_in,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              done,
    output logic              err
);
    typedef struct packed {
        step_e             step;
        logic [PRE_W-1:0]  pre;
        logic [MUL_W-1:0]  mul;
        logic [POST_W-1:0] post;
        logic              err;
    } seq_t;

    seq_t seq_d, seq_q;

    logic settle_exp, poll_exp, in_poll, busy_rd;
    logic [DATA_W-1:0] rdata_unused;

    assign in_poll      = (seq_q.step == ST_POLL_LOCK) || (seq_q.step == ST_POLL_CMD);
    assign busy_rd      = bus_rdata[BUSY_BIT];
    assign rdata_unused = bus_rdata;

    pllseq_interval #(.LIMIT(SETTLE_CYC)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (seq_q.step == ST_SETTLE),
        .expired (settle_exp)
    );

    pllseq_interval #(.LIMIT(POLL_LIMIT)) u_poll_to (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (in_poll),
        .expired (poll_exp)
    );

    pllseq_access_map #(
        .PRE_W  (PRE_W),
        .MUL_W  (MUL_W),
        .POST_W (POST_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_map (
        .step  (seq_q.step),
        .pre   (seq_q.pre),
        .mul   (seq_q.mul),
        .post  (seq_q.post),
        .req   (bus_req),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata)
    );

    always_comb begin
        seq_d = seq_q;
        case (seq_q.step)
            ST_IDLE: begin
                if (start) begin
                    seq_d.step = ST_OUT_OFF;
                    seq_d.pre  = pre_in;
                    seq_d.mul  = mul_in;
                    seq_d.post = post_in;
                    seq_d.err  = 1'b0;
                end
            end
            ST_OUT_OFF:   if (bus_ack) seq_d.step = ST_LOAD_PRE;
            ST_LOAD_PRE:  if (bus_ack) seq_d.step = ST_LOAD_MUL;
            ST_LOAD_MUL:  if (bus_ack) seq_d.step = ST_SETTLE;
            ST_SETTLE:    if (settle_exp) seq_d.step = ST_POLL_LOCK;
            ST_POLL_LOCK: begin
                if (bus_ack) begin
                    if (!busy_rd) begin
                        seq_d.step = ST_LOAD_POST;
                    end else if (poll_exp) begin
                        seq_d.step = ST_FINISH;
                        seq_d.err  = 1'b1;
                    end
                end
            end
            ST_LOAD_POST: if (bus_ack) seq_d.step = ST_ARM;
            ST_ARM:       if (bus_ack) seq_d.step = ST_FIRE;
            ST_FIRE:      if (bus_ack) seq_d.step = ST_POLL_CMD;
            ST_POLL_CMD: begin
                if (bus_ack) begin
                    if (!busy_rd) begin
                        seq_d.step = ST_OUT_ON;
                    end else if (poll_exp) begin
                        seq_d.step = ST_FINISH;
                        seq_d.err  = 1'b1;
                    end
                end
            end
            ST_OUT_ON:    if (bus_ack) seq_d.step = ST_FINISH;
            ST_FINISH:    seq_d.step = ST_IDLE;
            default:      seq_d.step = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{step: ST_IDLE, pre: '0, mul: '0, post: '0, err: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign done = (seq_q.step == ST_FINISH);
    assign err  = seq_q.err;
endmodule

// File: rtl/pllseq_checks.sv
module pllseq_checks #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ack,
    input logic              done,
    input logic              err
);
    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata))); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_QUIET_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_req); // R7

    AST_READ_STATUS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |-> (bus_addr == ADDR_W'(15))); // R5

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done); // R9
endmodule

bind pllseq_top pllseq_checks #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .done      (done),
    .err       (err)
);

// File: tb/pllseq_top_test.sv
module pllseq_top_test;
    localparam int SETTLE = 4;
    localparam int PLIM   = 60;

    logic clk = 0, rst_n = 0, start = 0;
    logic [4:0] pre_in = 0, post_in = 0;
    logic [3:0] mul_in = 0;
    logic bus_req, bus_we, bus_ack = 0, done, err;
    logic [4:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata = 0;

    always #2 clk = ~clk;

    pllseq_top #(.SETTLE_CYC(SETTLE), .POLL_LIMIT(PLIM)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .pre_in(pre_in), .mul_in(mul_in),
        .post_in(post_in), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .done(done), .err(err)
    );

    int nchk = 0, nfail = 0;

    // slave model configuration and transfer log
    int lat = 0, k1 = 0, k2 = 0, busy_left = 0, wcnt = 0;
    int lg_n = 0;
    logic [4:0]  lg_addr [0:255];
    logic        lg_we   [0:255];
    logic [31:0] lg_data [0:255];
    bit counting = 0, gap_seen = 0;
    int gap = 0;

    int ex_n = 0;
    logic [4:0]  ex_addr [0:63];
    logic        ex_we   [0:63];
    logic [31:0] ex_data [0:63];

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic push(input int a, input bit w, input int d);
        ex_addr[ex_n] = 5'(a); ex_we[ex_n] = w; ex_data[ex_n] = 32'(d); ex_n++;
    endtask

    task automatic push_reads(input int k);
        for (int i = 0; i <= k; i++) push(15, 1'b0, 0);
    endtask

    // bus slave: acknowledges after lat wait cycles, busy for k reads after a trigger
    initial begin
        forever begin
            @(negedge clk);
            if (counting) begin
                if (bus_req && !bus_we && bus_addr == 5'd15) begin
                    counting = 0; gap_seen = 1;
                end else if (!bus_req) begin
                    gap++;
                end
            end
            if (bus_ack) begin
                bus_ack = 0;
                bus_rdata = 0;
            end else if (bus_req) begin
                if (wcnt >= lat) begin
                    wcnt = 0;
                    bus_ack = 1;
                    if (lg_n < 256) begin
                        lg_addr[lg_n] = bus_addr; lg_we[lg_n] = bus_we; lg_data[lg_n] = bus_wdata;
                        lg_n++;
                    end
                    bus_rdata = 0;
                    if (!bus_we && bus_addr == 5'd15 && busy_left > 0) begin
                        bus_rdata = 32'h1;
                        busy_left--;
                    end
                    if (bus_we && bus_addr == 5'd4) begin
                        busy_left = k1; counting = 1; gap = 0;
                    end
                    if (bus_we && bus_addr == 5'd14) busy_left = k2;
                end else begin
                    wcnt++;
                end
            end
        end
    end

    // mode 0 normal, 1 abort in first poll, 2 abort in second poll, 3 disturbed inputs
    task automatic run_seq(input int pre, input int mul, input int post,
                           input int b1, input int b2, input int l, input int mode);
        bit got_done = 0, seq_ok = 1, got_err = 0;
        int extra_req = 0, pfx = 0;
        k1 = b1; k2 = b2; lat = l; lg_n = 0; ex_n = 0; gap_seen = 0; counting = 0;
        @(negedge clk);
        pre_in = 5'(pre); mul_in = 4'(mul); post_in = 5'(post); start = 1;
        @(negedge clk);
        start = 0;
        for (int c = 0; c < 3000; c++) begin
            if (c == 3 && mode == 3) begin
                pre_in = ~pre_in; mul_in = ~mul_in; post_in = ~post_in; start = 1;
            end
            if (c == 4) start = 0;
            if (done) begin got_done = 1; got_err = err; break; end
            @(negedge clk);
        end
        start = 0;
        chk(got_done, "R7", "done seen", got_done, 1);
        push(0, 1, 0); push(5, 1, 32'h8000 | pre); push(4, 1, mul);
        if (mode == 1) begin
            pfx = 3;
        end else begin
            push_reads(b1);
            push(6, 1, 32'h8000 | post); push(16, 1, 1); push(14, 1, 1);
            if (mode == 2) pfx = ex_n;
            else begin push_reads(b2); push(0, 1, 1); end
        end
        if (mode == 1 || mode == 2) begin
            for (int i = 0; i < pfx; i++)
                if (lg_addr[i] != ex_addr[i] || lg_we[i] != ex_we[i] || (ex_we[i] && lg_data[i] != ex_data[i]))
                    seq_ok = 0;
            for (int i = pfx; i < lg_n; i++)
                if (lg_we[i] || lg_addr[i] != 5'd15) seq_ok = 0;
            chk(seq_ok && lg_n > pfx, "R9", "abort: no writes after timeout", lg_n, pfx);
            chk(got_err == 1, "R9", "err with done", got_err, 1);
            repeat (5) @(negedge clk);
            chk(err == 1, "R11", "err held after abort", err, 1);
            chk(bus_req == 0, "R9", "bus quiet after abort", bus_req, 0);
        end else begin
            if (lg_n != ex_n) seq_ok = 0;
            for (int i = 0; i < ex_n && i < lg_n; i++)
                if (lg_addr[i] != ex_addr[i] || lg_we[i] != ex_we[i] || (ex_we[i] && lg_data[i] != ex_data[i])) begin
                    seq_ok = 0;
                    $display("FAIL R3/R6 entry %0d: actual addr %0d we %0d data %0h expected addr %0d we %0d data %0h",
                             i, lg_addr[i], lg_we[i], lg_data[i], ex_addr[i], ex_we[i], ex_data[i]);
                end
            chk(seq_ok, (mode == 3) ? "R10" : "R2 R3 R5 R6", "access sequence length", lg_n, ex_n);
            chk(got_err == 0, "R7", "err low on success", got_err, 0);
            if (mode == 3) begin
                for (int c = 0; c < 20; c++) begin
                    @(negedge clk);
                    if (bus_req) extra_req++;
                end
                chk(extra_req == 0, "R10", "no second sequence", extra_req, 0);
            end
        end
        chk(gap_seen && gap == SETTLE, "R4", "idle cycles before first status read", gap, SETTLE);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(bus_req == 0 && done == 0 && err == 0, "R1", "outputs during reset",
            {bus_req, done, err}, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk(bus_req == 0 && done == 0 && err == 0, "R1", "outputs after reset",
            {bus_req, done, err}, 0);

        // R2 R3 R4 R5 R6 R7 R8: sweep over values, busy counts and ack latency
        foreach (lat_v[li]) ;
        for (int p = 0; p < 3; p++)
            for (int m = 0; m < 3; m++)
                for (int q = 0; q < 2; q++)
                    for (int b = 0; b < 2; b++)
                        for (int l = 0; l < 2; l++)
                            run_seq((p == 0) ? 1 : (p == 1) ? 9 : 31,
                                    (m == 0) ? 1 : (m == 1) ? 8 : 15,
                                    (q == 0) ? 1 : 31,
                                    b * 2, (b == 0) ? 3 : 0, l * 2, 0);

        run_seq(7, 5, 12, 1, 1, 1, 3);     // R10
        run_seq(3, 6, 2, 1000, 0, 0, 1);   // R9 first poll
        run_seq(4, 2, 9, 1, 1, 0, 0);      // R11 err cleared by new start
        run_seq(11, 3, 20, 0, 1000, 1, 2); // R9 second poll

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    int lat_v [2] = '{0, 2};

    initial begin
        repeat (150000) @(posedge clk);
        nfail++; nchk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule